// File: doc/BRIEF.md
# Photovoltaic Start-up and Bypass Mode Sequencer

This block is the top-level mode controller of a panel power optimiser. It decides, cycle by cycle, whether the downstream buck-boost stage should be ramping up, waiting for load current, tracking the maximum power point, or stepping aside so that the panel feeds the output directly (bypass). It does not measure anything itself. It takes an already converted output-current code, a power code, a flag from the regulator saying that the converter sits at a 1:1 voltage ratio, an active-low pin that forces bypass, and a handful of static configuration selects.

All timing comes from a tick prescaler. One tick is nominally 1 ms, so soft-start, the start-up bypass period, the 1:1 dwell, the periodic re-check interval and the length of the re-check window are all counts of ticks set by parameters. Output-current thresholds are hysteretic. Leaving bypass on a change of power is judged against the power captured when bypass was entered, using a shift by 5 or by 6 as the allowed band.

Top module: `pv_mode_sequencer`

## Requirements
- R1: While `rst_n` is low, `mode_o` is 0 (reset) from any state. At the first clock edge with `rst_n` high, `mode_o` becomes 1 (soft-start). `mode_o` only ever takes the codes 0 reset, 1 soft-start, 2 start-up bypass, 3 tracking, 4 bypass.
- R2: `ss_req_o` is high exactly while the mode is soft-start. Soft-start lasts SS_TICKS ticks.
- R3: When soft-start ends, the mode becomes tracking if `iout_code` is at or above the selected start threshold, and start-up bypass otherwise.
- R4: Start-up bypass moves to tracking only when `iout_code` is at or above the start threshold and the selected start-up time has elapsed since entry. For `cfg_start_sel`, 0 gives zero ticks, 1 gives BST_T1 and 2 or 3 give BST_T2.
- R5: The thresholds are hysteretic. `cfg_thr_sel` 0 selects the pair THR_HI_A/THR_LO_A and 1 selects THR_HI_B/THR_LO_B. Tracking falls back to start-up bypass only when `iout_code` is strictly below the selected exit (low) threshold.
- R6: In tracking, if `ratio_unity` stays high for the dwell selected by `cfg_dwell_sel`, the mode becomes bypass. The codes 0..3 select DWELL0..DWELL3 ticks. Any cycle with `ratio_unity` low restarts the dwell.
- R7: With `force_byp_n` low, soft-start, start-up bypass and tracking all move to bypass at the next clock edge.
- R8: While in bypass with `force_byp_n` low, the mode stays in bypass regardless of the re-check timer or of power changes. The re-check interval restarts when the pin is released.
- R9: After RECHECK_TICKS ticks in bypass, the mode switches to tracking for a window of RUN_TICKS ticks. At the end of the window it goes back to bypass if `ratio_unity` is high. If `ratio_unity` is low, tracking simply continues.
- R10: In bypass, with P_e the `pwr_code` captured on entry to bypass, the mode switches to tracking at the next edge when |`pwr_code` − P_e| > P_e >> k. Here k is 5 when `cfg_var_sel` is 0 and 6 when it is 1. A difference equal to the band does not exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; returns the sequencer to reset |
| iout_code | input | ADC_W | Measured output-current code |
| pwr_code | input | PWR_W | Measured power code |
| force_byp_n | input | 1 | Active-low request to force bypass |
| ratio_unity | input | 1 | Converter currently at 1:1 voltage ratio |
| cfg_thr_sel | input | 1 | Selects the start/exit current threshold pair |
| cfg_start_sel | input | 2 | Selects the start-up bypass duration |
| cfg_dwell_sel | input | 2 | Selects the 1:1 dwell before bypass |
| cfg_var_sel | input | 1 | Power-change band: 0 gives >>5, 1 gives >>6 |
| mode_o | output | 3 | Current mode code (see R1) |
| ss_req_o | output | 1 | Request to run the soft-start ramp |

## Verification
The stimulus walks the sequencer through every mode via each legal exit, and times every transition against a tick-derived window so that an off-by-one tick or a wrong limit selection shows. Currents are placed between the two thresholds and exactly on the exit threshold, which separates true hysteresis from a single comparator. The power code is stepped to exactly the band and then one code beyond it for both shifts, and the second round uses a different entry power, so a missed capture of the entry power is exposed. An interrupted 1:1 dwell, a re-check window ending with and without the 1:1 flag, and the force pin applied in each non-reset mode and held across a re-check interval cover the priority order.

// File: rtl/pvseq_pkg.sv
package pvseq_pkg;

    typedef enum logic [2:0] {
        MD_RESET  = 3'd0,
        MD_SOFT   = 3'd1,
        MD_BSTART = 3'd2,
        MD_MPPT   = 3'd3,
        MD_BYPASS = 3'd4
    } pv_mode_e;

    typedef struct packed {
        pv_mode_e mode;
        logic     recheck;
    } seq_state_t;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned lim);
        return (lim < 1) ? 1 : $clog2(lim + 1);
    endfunction

endpackage

// File: rtl/pvseq_tick_gen.sv
module pvseq_tick_gen #(
    parameter int unsigned DIV = 100000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    generate
        if (DIV <= 1) begin : g_every
            logic unused_ok;
            assign unused_ok = clk ^ rst_n;
            assign tick_o    = 1'b1;
        end else begin : g_div
            localparam int unsigned CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);

            logic [CW-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign tick_o = (cnt_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/pvseq_tick_timer.sv
module pvseq_tick_timer #(
    parameter int unsigned W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         tick_i,
    output logic [W-1:0] cnt_o
);

    logic [W-1:0] cnt_d, cnt_q;

    // Saturating tick counter; a clear wins over a coincident tick.
    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (tick_i && (cnt_q != '1))
            cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/pvseq_pwr_var.sv
module pvseq_pwr_var #(
    parameter int unsigned PW           = 16,
    parameter int unsigned SHIFT_COARSE = 5,
    parameter int unsigned SHIFT_FINE   = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture_i,
    input  logic          fine_i,
    input  logic [PW-1:0] pwr_i,
    output logic          var_o
);

    logic [PW-1:0] ref_d, ref_q;
    logic [PW-1:0] delta, band;

    always_comb begin
        ref_d = capture_i ? pwr_i : ref_q;
        delta = (pwr_i >= ref_q) ? (pwr_i - ref_q) : (ref_q - pwr_i);
        band  = fine_i ? (ref_q >> SHIFT_FINE) : (ref_q >> SHIFT_COARSE);
        var_o = (delta > band);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ref_q <= '0;
        else        ref_q <= ref_d;
    end

endmodule

// File: rtl/pv_mode_sequencer.sv
module pv_mode_sequencer
    import pvseq_pkg::*;
#(
    parameter int unsigned ADC_W         = 10,
    parameter int unsigned PWR_W         = 16,
    parameter int unsigned TICK_DIV      = 100000,
    parameter int unsigned SS_TICKS      = 250,
    parameter int unsigned BST_T1        = 60000,
    parameter int unsigned BST_T2        = 120000,
    parameter int unsigned DWELL0        = 200,
    parameter int unsigned DWELL1        = 400,
    parameter int unsigned DWELL2        = 1000,
    parameter int unsigned DWELL3        = 2000,
    parameter int unsigned RECHECK_TICKS = 60000,
    parameter int unsigned RUN_TICKS     = 4000,
    parameter int unsigned THR_HI_A      = 400,
    parameter int unsigned THR_LO_A      = 100,
    parameter int unsigned THR_HI_B      = 240,
    parameter int unsigned THR_LO_B      = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ADC_W-1:0] iout_code,
    input  logic [PWR_W-1:0] pwr_code,
    input  logic             force_byp_n,
    input  logic             ratio_unity,
    input  logic             cfg_thr_sel,
    input  logic [1:0]       cfg_start_sel,
    input  logic [1:0]       cfg_dwell_sel,
    input  logic             cfg_var_sel,
    output logic [2:0]       mode_o,
    output logic             ss_req_o
);

    localparam int unsigned TMR_MAX = umax(umax(SS_TICKS, RUN_TICKS),
                                           umax(RECHECK_TICKS, umax(BST_T1, BST_T2)));
    localparam int unsigned DWL_MAX = umax(umax(DWELL0, DWELL1), umax(DWELL2, DWELL3));
    localparam int unsigned TMR_W   = cnt_width(TMR_MAX);
    localparam int unsigned DWL_W   = cnt_width(DWL_MAX);

    localparam logic [ADC_W-1:0] HI_A = ADC_W'(THR_HI_A);
    localparam logic [ADC_W-1:0] LO_A = ADC_W'(THR_LO_A);
    localparam logic [ADC_W-1:0] HI_B = ADC_W'(THR_HI_B);
    localparam logic [ADC_W-1:0] LO_B = ADC_W'(THR_LO_B);

    localparam logic [TMR_W-1:0] LIM_SS  = TMR_W'(SS_TICKS);
    localparam logic [TMR_W-1:0] LIM_T1  = TMR_W'(BST_T1);
    localparam logic [TMR_W-1:0] LIM_T2  = TMR_W'(BST_T2);
    localparam logic [TMR_W-1:0] LIM_RC  = TMR_W'(RECHECK_TICKS);
    localparam logic [TMR_W-1:0] LIM_RUN = TMR_W'(RUN_TICKS);

    seq_state_t       st_d, st_q;
    logic             tick;
    logic [TMR_W-1:0] tmr;
    logic [DWL_W-1:0] dwl;
    logic             tmr_clr, dwl_clr, capture, pwr_moved, chg;
    logic [ADC_W-1:0] thr_hi, thr_lo;
    logic [TMR_W-1:0] start_lim;
    logic [DWL_W-1:0] dwell_lim;
    logic             forced;

    pvseq_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    // Time spent in the current mode (held at zero while bypass is forced).
    pvseq_tick_timer #(.W(TMR_W)) u_mode_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (tmr_clr),
        .tick_i (tick),
        .cnt_o  (tmr)
    );

    // Uninterrupted time at 1:1 ratio while tracking.
    pvseq_tick_timer #(.W(DWL_W)) u_dwell_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (dwl_clr),
        .tick_i (tick),
        .cnt_o  (dwl)
    );

    pvseq_pwr_var #(.PW(PWR_W), .SHIFT_COARSE(5), .SHIFT_FINE(6)) u_pvar (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture),
        .fine_i    (cfg_var_sel),
        .pwr_i     (pwr_code),
        .var_o     (pwr_moved)
    );

    always_comb begin
        forced = !force_byp_n;
        thr_hi = cfg_thr_sel ? HI_B : HI_A;
        thr_lo = cfg_thr_sel ? LO_B : LO_A;

        case (cfg_start_sel)
            2'd0:    start_lim = '0;
            2'd1:    start_lim = LIM_T1;
            default: start_lim = LIM_T2;
        endcase

        case (cfg_dwell_sel)
            2'd0:    dwell_lim = DWL_W'(DWELL0);
            2'd1:    dwell_lim = DWL_W'(DWELL1);
            2'd2:    dwell_lim = DWL_W'(DWELL2);
            default: dwell_lim = DWL_W'(DWELL3);
        endcase

        st_d = st_q;
        unique case (st_q.mode)
            MD_RESET: begin
                st_d.mode    = MD_SOFT;
                st_d.recheck = 1'b0;
            end
            MD_SOFT: begin
                if (forced)
                    st_d.mode = MD_BYPASS;
                else if (tmr >= LIM_SS)
                    st_d.mode = (iout_code >= thr_hi) ? MD_MPPT : MD_BSTART;
            end
            MD_BSTART: begin
                if (forced)
                    st_d.mode = MD_BYPASS;
                else if ((iout_code >= thr_hi) && (tmr >= start_lim))
                    st_d.mode = MD_MPPT;
            end
            MD_MPPT: begin
                if (forced) begin
                    st_d.mode    = MD_BYPASS;
                    st_d.recheck = 1'b0;
                end else if (iout_code < thr_lo) begin
                    st_d.mode    = MD_BSTART;
                    st_d.recheck = 1'b0;
                end else if (dwl >= dwell_lim) begin
                    st_d.mode    = MD_BYPASS;
                    st_d.recheck = 1'b0;
                end else if (st_q.recheck && (tmr >= LIM_RUN)) begin
                    st_d.recheck = 1'b0;
                    if (ratio_unity)
                        st_d.mode = MD_BYPASS;
                end
            end
            MD_BYPASS: begin
                if (!forced) begin
                    if (tmr >= LIM_RC) begin
                        st_d.mode    = MD_MPPT;
                        st_d.recheck = 1'b1;
                    end else if (pwr_moved) begin
                        st_d.mode    = MD_MPPT;
                        st_d.recheck = 1'b0;
                    end
                end
            end
            default: begin
                st_d.mode    = MD_RESET;
                st_d.recheck = 1'b0;
            end
        endcase

        chg     = (st_d.mode != st_q.mode);
        tmr_clr = chg || ((st_q.mode == MD_BYPASS) && forced);
        dwl_clr = chg || (st_q.mode != MD_MPPT) || !ratio_unity;
        capture = chg && (st_d.mode == MD_BYPASS);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MD_RESET, recheck: 1'b0};
        else        st_q <= st_d;
    end

    assign mode_o   = st_q.mode;
    assign ss_req_o = (st_q.mode == MD_SOFT);

endmodule

// File: rtl/pvseq_checker.sv
module pvseq_checker #(
    parameter int unsigned ADC_W    = 10,
    parameter int unsigned THR_HI_A = 400,
    parameter int unsigned THR_LO_A = 100,
    parameter int unsigned THR_HI_B = 240,
    parameter int unsigned THR_LO_B = 60
) (
    input logic             clk,
    input logic             rst_n,
    input logic [ADC_W-1:0] iout_code,
    input logic             force_byp_n,
    input logic             cfg_thr_sel,
    input logic [2:0]       mode_o,
    input logic             ss_req_o
);

    logic [ADC_W-1:0] hi, lo;
    assign hi = cfg_thr_sel ? ADC_W'(THR_HI_B) : ADC_W'(THR_HI_A);
    assign lo = cfg_thr_sel ? ADC_W'(THR_LO_B) : ADC_W'(THR_LO_A);

    a_r1_legal_mode: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o <= 3'd4);

    a_r1_reset_to_soft: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd0) |=> (mode_o == 3'd1));

    a_r2_ss_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_req_o) |-> ($past(mode_o) == 3'd0));

    a_r3_soft_high_current: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o == 3'd1) && force_byp_n && (iout_code >= hi)) |=> (mode_o != 3'd2));

    a_r4_bstart_waits_current: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o == 3'd2) && force_byp_n && (iout_code < hi)) |=> (mode_o == 3'd2));

    a_r5_hysteresis_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o == 3'd3) && force_byp_n && (iout_code >= lo)) |=> (mode_o != 3'd2));

    a_r7_force_to_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        (!force_byp_n && (mode_o >= 3'd1) && (mode_o <= 3'd3)) |=> (mode_o == 3'd4));

    a_r8_forced_bypass_holds: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o == 3'd4) && !force_byp_n) |=> (mode_o == 3'd4));

endmodule

bind pv_mode_sequencer pvseq_checker #(
    .ADC_W    (ADC_W),
    .THR_HI_A (THR_HI_A),
    .THR_LO_A (THR_LO_A),
    .THR_HI_B (THR_HI_B),
    .THR_LO_B (THR_LO_B)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .iout_code   (iout_code),
    .force_byp_n (force_byp_n),
    .cfg_thr_sel (cfg_thr_sel),
    .mode_o      (mode_o),
    .ss_req_o    (ss_req_o)
);

// File: tb/sim_pv_mode_sequencer.sv
module sim_pv_mode_sequencer;

    localparam int TD  = 4;
    localparam int SS  = 10;
    localparam int T1  = 20;
    localparam int T2  = 40;
    localparam int D0  = 3;
    localparam int D1  = 5;
    localparam int D2  = 8;
    localparam int D3  = 12;
    localparam int RC  = 50;
    localparam int RUN = 6;
    localparam int HA  = 200;
    localparam int LA  = 50;
    localparam int HB  = 120;
    localparam int LB  = 30;

    localparam logic [2:0] M_RST = 3'd0, M_SOFT = 3'd1, M_BST = 3'd2, M_MPPT = 3'd3, M_BYP = 3'd4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic [9:0]  iout_code = '0;
    logic [15:0] pwr_code = 16'd640;
    logic        force_byp_n = 1'b1;
    logic        ratio_unity = 1'b0;
    logic        cfg_thr_sel = 1'b0;
    logic [1:0]  cfg_start_sel = 2'd1;
    logic [1:0]  cfg_dwell_sel = 2'd1;
    logic        cfg_var_sel = 1'b0;
    logic [2:0]  mode_o;
    logic        ss_req_o;

    pv_mode_sequencer #(
        .ADC_W(10), .PWR_W(16), .TICK_DIV(TD), .SS_TICKS(SS),
        .BST_T1(T1), .BST_T2(T2),
        .DWELL0(D0), .DWELL1(D1), .DWELL2(D2), .DWELL3(D3),
        .RECHECK_TICKS(RC), .RUN_TICKS(RUN),
        .THR_HI_A(HA), .THR_LO_A(LA), .THR_HI_B(HB), .THR_LO_B(LB)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .iout_code(iout_code), .pwr_code(pwr_code),
        .force_byp_n(force_byp_n), .ratio_unity(ratio_unity),
        .cfg_thr_sel(cfg_thr_sel), .cfg_start_sel(cfg_start_sel),
        .cfg_dwell_sel(cfg_dwell_sel), .cfg_var_sel(cfg_var_sel),
        .mode_o(mode_o), .ss_req_o(ss_req_o)
    );

    typedef struct {
        logic [2:0] mode;
        int         ref_cyc;
        int         lo;
        int         hi;
        string      req;
    } exp_t;

    exp_t       sb[$];
    int         cyc = 0;
    int         n_chk = 0;
    int         n_fail = 0;
    logic [2:0] prev_mode = 3'd0;
    int         last_chg = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int wlo(input int l); return (l - 1) * TD; endfunction
    function automatic int whi(input int l); return l * TD + 2; endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Driver side: push an expected transition; from_now=0 times it from the previous change.
    task automatic expect_mode(input logic [2:0] m, input bit from_now, input int lo, input int hi,
                               input string req);
        exp_t e;
        e.mode = m; e.ref_cyc = from_now ? cyc : -1; e.lo = lo; e.hi = hi; e.req = req;
        sb.push_back(e);
    endtask

    // Monitor: compare every mode change with the scoreboard head.
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_mode = M_RST;
            last_chg  = cyc;
        end else if (mode_o != prev_mode) begin
            if (sb.size() == 0) begin
                check(1'b0, "R1", "unexpected mode change", int'(mode_o), int'(prev_mode));
            end else begin
                exp_t e;
                int   base, dur;
                e    = sb.pop_front();
                base = (e.ref_cyc < 0) ? last_chg : e.ref_cyc;
                dur  = cyc - base;
                check(mode_o == e.mode, e.req, "mode", int'(mode_o), int'(e.mode));
                check((dur >= e.lo) && (dur <= e.hi), e.req, "transition delay", dur, e.lo);
            end
            prev_mode = mode_o;
            last_chg  = cyc;
        end
    end

    task automatic wait_for(input logic [2:0] m, input string req);
        int n = 0;
        while ((mode_o != m) && (n < 5000)) begin
            @(negedge clk);
            n++;
        end
        if (mode_o != m) check(1'b0, req, "mode never reached", int'(mode_o), int'(m));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(mode_o == M_RST, "R1", "mode in reset", int'(mode_o), 0);
        check(ss_req_o == 1'b0, "R1", "ss_req in reset", int'(ss_req_o), 0);
        expect_mode(M_SOFT, 1'b1, 0, 2, "R1");
        rst_n = 1'b1;
        wait_for(M_SOFT, "R1");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1/R2/R3/R4: low current in soft-start, then start-up bypass of T1 ticks
        do_reset();
        expect_mode(M_BST, 1'b0, wlo(SS), whi(SS), "R3");
        repeat (3) @(negedge clk);
        check(ss_req_o == 1'b1, "R2", "ss_req in soft-start", int'(ss_req_o), 1);
        wait_for(M_BST, "R3");
        @(negedge clk);
        check(ss_req_o == 1'b0, "R2", "ss_req after soft-start", int'(ss_req_o), 0);
        expect_mode(M_MPPT, 1'b0, wlo(T1), whi(T1), "R4");
        repeat (40) @(negedge clk);
        iout_code = 10'd250;
        wait_for(M_MPPT, "R4");

        // R5: hysteresis with both threshold pairs, R4 with zero start time
        cfg_start_sel = 2'd0;
        iout_code = 10'd100;
        repeat (30) @(negedge clk);
        check(mode_o == M_MPPT, "R5", "mid current keeps tracking", int'(mode_o), int'(M_MPPT));
        expect_mode(M_BST, 1'b1, 0, 2, "R5");
        iout_code = 10'd40;
        wait_for(M_BST, "R5");
        iout_code = 10'd150;
        repeat (20) @(negedge clk);
        check(mode_o == M_BST, "R4", "below start threshold A", int'(mode_o), int'(M_BST));
        expect_mode(M_MPPT, 1'b1, 0, 2, "R5");
        cfg_thr_sel = 1'b1;
        wait_for(M_MPPT, "R5");
        iout_code = 10'd40;
        repeat (20) @(negedge clk);
        check(mode_o == M_MPPT, "R5", "above exit threshold B", int'(mode_o), int'(M_MPPT));
        iout_code = 10'd250;
        cfg_thr_sel = 1'b0;

        // R6: interrupted dwell, then full dwell of D1 ticks
        ratio_unity = 1'b1;
        repeat (12) @(negedge clk);
        ratio_unity = 1'b0;
        repeat (20) @(negedge clk);
        check(mode_o == M_MPPT, "R6", "interrupted dwell", int'(mode_o), int'(M_MPPT));
        expect_mode(M_BYP, 1'b1, wlo(D1), whi(D1), "R6");
        ratio_unity = 1'b1;
        wait_for(M_BYP, "R6");

        // R10: band boundary with shift 5 (entry power 640, band 20)
        pwr_code = 16'd660;
        repeat (20) @(negedge clk);
        check(mode_o == M_BYP, "R10", "change equal to band k=5", int'(mode_o), int'(M_BYP));
        expect_mode(M_MPPT, 1'b1, 0, 2, "R10");
        expect_mode(M_BYP, 1'b0, wlo(D1), whi(D1), "R6");
        pwr_code = 16'd661;
        wait_for(M_MPPT, "R10");
        wait_for(M_BYP, "R6");
        // R10: shift 6 against the new entry power 661 (band 10)
        cfg_var_sel = 1'b1;
        pwr_code = 16'd671;
        repeat (20) @(negedge clk);
        check(mode_o == M_BYP, "R10", "change equal to band k=6", int'(mode_o), int'(M_BYP));
        expect_mode(M_MPPT, 1'b1, 0, 2, "R10");
        expect_mode(M_BYP, 1'b0, wlo(D1), whi(D1), "R6");
        pwr_code = 16'd672;
        wait_for(M_MPPT, "R10");
        wait_for(M_BYP, "R6");

        // R9: periodic re-check; window ends at 1:1, then a window ending off 1:1
        cfg_dwell_sel = 2'd3;
        expect_mode(M_MPPT, 1'b0, wlo(RC), whi(RC), "R9");
        expect_mode(M_BYP, 1'b0, wlo(RUN), whi(RUN), "R9");
        wait_for(M_MPPT, "R9");
        wait_for(M_BYP, "R9");
        expect_mode(M_MPPT, 1'b0, wlo(RC), whi(RC), "R9");
        wait_for(M_MPPT, "R9");
        ratio_unity = 1'b0;
        repeat (RUN * TD + 20) @(negedge clk);
        check(mode_o == M_MPPT, "R9", "window end off 1:1 keeps tracking", int'(mode_o), int'(M_MPPT));
        expect_mode(M_BYP, 1'b1, wlo(D3), whi(D3), "R6");
        ratio_unity = 1'b1;
        wait_for(M_BYP, "R6");

        // R8: forced bypass ignores re-check and power change
        force_byp_n = 1'b0;
        pwr_code = 16'd900;
        repeat (150) @(negedge clk);
        check(mode_o == M_BYP, "R8", "forced, power changed", int'(mode_o), int'(M_BYP));
        repeat (150) @(negedge clk);
        check(mode_o == M_BYP, "R8", "forced past re-check interval", int'(mode_o), int'(M_BYP));
        ratio_unity = 1'b0;
        expect_mode(M_MPPT, 1'b1, 0, 2, "R10");
        force_byp_n = 1'b1;
        wait_for(M_MPPT, "R10");
        // R7: force from tracking
        repeat (5) @(negedge clk);
        expect_mode(M_BYP, 1'b1, 0, 2, "R7");
        force_byp_n = 1'b0;
        wait_for(M_BYP, "R7");
        force_byp_n = 1'b1;
        repeat (5) @(negedge clk);

        // R7: force from soft-start
        cfg_start_sel = 2'd2;
        iout_code = 10'd0;
        do_reset();
        repeat (3) @(negedge clk);
        expect_mode(M_BYP, 1'b1, 0, 2, "R7");
        force_byp_n = 1'b0;
        wait_for(M_BYP, "R7");
        force_byp_n = 1'b1;
        repeat (5) @(negedge clk);

        // R7: force from start-up bypass
        do_reset();
        expect_mode(M_BST, 1'b0, wlo(SS), whi(SS), "R3");
        wait_for(M_BST, "R3");
        repeat (5) @(negedge clk);
        expect_mode(M_BYP, 1'b1, 0, 2, "R7");
        force_byp_n = 1'b0;
        wait_for(M_BYP, "R7");
        force_byp_n = 1'b1;
        repeat (5) @(negedge clk);

        // R3: high current in soft-start; R5 exit boundary; R4 with T2
        iout_code = 10'd250;
        do_reset();
        expect_mode(M_MPPT, 1'b0, wlo(SS), whi(SS), "R3");
        wait_for(M_MPPT, "R3");
        iout_code = 10'(LA);
        repeat (10) @(negedge clk);
        check(mode_o == M_MPPT, "R5", "current equal to exit threshold", int'(mode_o), int'(M_MPPT));
        expect_mode(M_BST, 1'b1, 0, 2, "R5");
        iout_code = 10'(LA - 1);
        wait_for(M_BST, "R5");
        expect_mode(M_MPPT, 1'b0, wlo(T2), whi(T2), "R4");
        iout_code = 10'd250;
        wait_for(M_MPPT, "R4");

        repeat (5) @(negedge clk);
        check(sb.size() == 0, "R1", "pending expected transitions", sb.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule